// File: doc/BRIEF.md
# DS3 C-bit Overhead Frame Generator

This block sits in the transmit path of a DS3 line interface that uses the C-bit parity format. It takes a serial payload stream with a per-bit enable and keeps track of where each bit falls in the 4760-bit multiframe. It writes generated values into every overhead position and lets payload positions through unchanged. The multiframe has seven subframes of 680 bits. Each subframe has eight 85-bit blocks, and each block is one overhead bit followed by 84 payload bits. Inside a subframe the overhead order is: the subframe-specific bit, F1, C1, F2, C2, F3, C3, F4. The subframe-specific bits are X1, X2, P1, P2, M1, M2, M3, in that order.

Several values are taken once per multiframe, on the bit that opens it, and then held for the rest of the frame: the remote-defect value for the X bits, the alarm-control bit in C13, and the far-end block-error value for the C4 row. Each frame's parity bits carry the modulo-2 sum of the payload of the frame before. A bypass mode passes the stream through untouched, except that the P bits can still be rewritten. The output is registered. A strobe marks the output bit that opens each multiframe.

Top module: `ds3cb_ovh_gen`

## Requirements
- R1: Multiframe position starts at X1 with the first bit accepted after reset and advances only on cycles with `bit_en` high, wrapping after 4760 accepted bits; `mf_strobe` is 1 together with the output of X1 and 0 for every other bit.
- R2: Any bit that is not the first bit of its 85-bit block is output equal to its input in every mode.
- R3: With `frame_gen_en`=1, the four F bits of every subframe are output as 1,0,0,1 in order, and M1,M2,M3 as 0,1,0.
- R4: With `frame_gen_en`=1, X1 and X2 both carry the frame's RDI value; `rdi_mode` 2'b01 forces it to 0, 2'b10 and 2'b11 force it to 1.
- R5: With `rdi_mode`=2'b00, RDI is 0 if any `alarm_stat[k]` with `alarm_en[k]` set is 1, else 1; index 0 is loss of signal, 1 severely errored frame, 2 loss of frame, 3 alarm indication signal.
- R6: P1, P2 and (with `frame_gen_en`=1) C31..C33 carry the XOR of all 4704 payload bits of the previous multiframe; in the first multiframe after reset they are 0.
- R7: With `frame_gen_en`=1, C11, C12, C21..C23 and C61..C73 are output as 1, C13 as the frame's alarm-control value, and C51..C53 as `dl_bit` at that bit's own input cycle.
- R8: With `frame_gen_en`=1, C41..C43 carry the frame's FEBE value: `febe_reg` when `febe_auto`=0, otherwise 0 if `cpar_err` was high in any cycle of the previous multiframe and 1 if it never was.
- R9: With `frame_gen_en`=0, every bit is output equal to its input, except P1 and P2, which carry the parity of R6 when `pbit_gen_en`=1.
- R10: `rdi_mode`, `alarm_en`, `alarm_stat`, `feac_bit`, `febe_auto` and `febe_reg` are sampled on the X1 bit only; changing them later in the frame does not affect X2, C13 or C4x of that frame.
- R11: Each accepted bit appears on `dout` with `dout_vld`=1 on the clock edge after its input edge; on cycles with `bit_en`=0 the next output has `dout_vld`=0 and `dout` unchanged; in reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Accepts `din` as the next stream bit |
| din | input | 1 | Incoming payload stream bit |
| frame_gen_en | input | 1 | Enables overhead generation; 0 selects bypass |
| pbit_gen_en | input | 1 | Enables P-bit generation in bypass |
| rdi_mode | input | 2 | RDI source: 00 automatic, 01 zero, 1x one |
| alarm_en | input | 4 | Per-alarm enable for automatic RDI |
| alarm_stat | input | 4 | Current alarm flags |
| febe_auto | input | 1 | Selects automatic FEBE |
| febe_reg | input | 1 | FEBE value when not automatic |
| cpar_err | input | 1 | C-bit parity error flag from the receive side |
| feac_bit | input | 1 | Alarm-and-control channel bit for C13 |
| dl_bit | input | 1 | Path data link bit for C51..C53 |
| dout | output | 1 | Framed output stream |
| dout_vld | output | 1 | `dout` holds a new bit |
| mf_strobe | output | 1 | Marks the X1 output bit |

## Verification
The assertions assume that `bit_en` and `din` are clean synchronous levels. They also assume that the stream runs only in whole multiframes counted from reset, so the internal position always matches the bench's notion of the boundary. The stimulus changes inputs only on falling edges, always feeds complete 4760-bit frames and holds `cpar_err` to single-cycle pulses. Control changes in the middle of a frame happen only in the scenario that checks the per-frame sampling, and always after X1.

// File: rtl/ds3cb_pkg.sv
`timescale 1ns/1ps
package ds3cb_pkg;

  typedef enum logic [1:0] {
    RDI_AUTO    = 2'b00,
    RDI_FORCE0  = 2'b01,
    RDI_FORCE1  = 2'b10,
    RDI_FORCE1B = 2'b11
  } rdi_mode_e;

  // values held for one multiframe
  typedef struct packed {
    logic rdi;
    logic feac;
    logic febe;
  } frame_snap_t;

  // bit k is the value of F(k+1) / M(k+1)
  localparam logic [3:0] F_PATTERN = 4'b1001;
  localparam logic [2:0] M_PATTERN = 3'b010;

endpackage

// File: rtl/ds3cb_pos_ctr.sv
`timescale 1ns/1ps
module ds3cb_pos_ctr #(
  parameter int SUBFRAMES  = 7,
  parameter int BLOCKS     = 8,
  parameter int BLOCK_BITS = 85,
  parameter int SUB_W      = $clog2(SUBFRAMES),
  parameter int BLK_W      = $clog2(BLOCKS),
  parameter int BIT_W      = $clog2(BLOCK_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [SUB_W-1:0] sub_idx,
  output logic [BLK_W-1:0] blk_idx,
  output logic [BIT_W-1:0] bit_idx,
  output logic             at_start,
  output logic             at_last
);

  logic [SUB_W-1:0] sub_q, sub_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             sub_end, blk_end, bit_end;

  assign sub_end = (sub_q == SUB_W'(SUBFRAMES - 1));
  assign blk_end = (blk_q == BLK_W'(BLOCKS - 1));
  assign bit_end = (bit_q == BIT_W'(BLOCK_BITS - 1));

  always_comb begin
    sub_d = sub_q;
    blk_d = blk_q;
    bit_d = bit_q + 1'b1;
    if (bit_end) begin
      bit_d = '0;
      if (blk_end) begin
        blk_d = '0;
        sub_d = sub_end ? '0 : sub_q + 1'b1;
      end else begin
        blk_d = blk_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
      blk_q <= '0;
      bit_q <= '0;
    end else if (adv) begin
      sub_q <= sub_d;
      blk_q <= blk_d;
      bit_q <= bit_d;
    end
  end

  assign sub_idx  = sub_q;
  assign blk_idx  = blk_q;
  assign bit_idx  = bit_q;
  assign at_start = (sub_q == '0) && (blk_q == '0) && (bit_q == '0);
  assign at_last  = sub_end && blk_end && bit_end;

  assert_pos_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bit_q) < BLOCK_BITS) && (int'(blk_q) < BLOCKS) && (int'(sub_q) < SUBFRAMES));

  assert_wrap_to_x1_R1: assert property (@(posedge clk) disable iff (!rst_n)
    adv && at_last |=> at_start);

  assert_hold_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable({sub_q, blk_q, bit_q}));

endmodule

// File: rtl/ds3cb_parity.sv
`timescale 1ns/1ps
module ds3cb_parity (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic at_last,
  input  logic is_payload,
  input  logic din,
  input  logic cpar_err,
  output logic par_prev,
  output logic err_prev
);

  logic acc_q, acc_d;
  logic par_q, par_d;
  logic seen_q, seen_d;
  logic err_q, err_d;
  logic closing;

  assign closing = adv && at_last;

  always_comb begin
    acc_d = acc_q ^ (is_payload & din);
    par_d = par_q;
    if (at_last) begin
      par_d = acc_d;
      acc_d = 1'b0;
    end
  end

  always_comb begin
    seen_d = seen_q | cpar_err;
    err_d  = err_q;
    if (closing) begin
      err_d  = seen_d;
      seen_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      par_q <= 1'b0;
    end else if (adv) begin
      acc_q <= acc_d;
      par_q <= par_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      seen_q <= seen_d;
      err_q  <= err_d;
    end
  end

  assign par_prev = par_q;
  assign err_prev = err_q;

  assert_parity_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !closing |=> $stable(par_q));

  assert_acc_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    closing |=> !acc_q);

  assert_err_captured_R8: assert property (@(posedge clk) disable iff (!rst_n)
    closing && cpar_err |=> err_q && !seen_q);

endmodule

// File: rtl/ds3cb_ovh_sel.sv
`timescale 1ns/1ps
module ds3cb_ovh_sel #(
  parameter int SUB_W = 3,
  parameter int BLK_W = 3,
  parameter int BIT_W = 7
) (
  input  logic             [SUB_W-1:0] sub_idx,
  input  logic             [BLK_W-1:0] blk_idx,
  input  logic             [BIT_W-1:0] bit_idx,
  input  logic                         din,
  input  logic                         frame_gen_en,
  input  logic                         pbit_gen_en,
  input  ds3cb_pkg::frame_snap_t       snap,
  input  logic                         dl_bit,
  input  logic                         par_prev,
  output logic                         dout_nxt
);
  import ds3cb_pkg::*;

  logic [1:0] f_sel;
  logic [1:0] m_sel;

  assign f_sel = 2'(blk_idx >> 1);
  assign m_sel = 2'(sub_idx - SUB_W'(4));

  always_comb begin
    dout_nxt = din;
    if (bit_idx == '0) begin
      if (blk_idx == '0) begin
        // subframe-specific bit: X, X, P, P, M, M, M
        if (sub_idx < SUB_W'(2)) begin
          if (frame_gen_en) dout_nxt = snap.rdi;
        end else if (sub_idx < SUB_W'(4)) begin
          if (frame_gen_en || pbit_gen_en) dout_nxt = par_prev;
        end else begin
          if (frame_gen_en) dout_nxt = M_PATTERN[m_sel];
        end
      end else if (blk_idx[0]) begin
        if (frame_gen_en) dout_nxt = F_PATTERN[f_sel];
      end else if (frame_gen_en) begin
        // C bits; row is subframe, column is block/2
        case (sub_idx)
          SUB_W'(0): dout_nxt = (blk_idx == BLK_W'(6)) ? snap.feac : 1'b1;
          SUB_W'(2): dout_nxt = par_prev;
          SUB_W'(3): dout_nxt = snap.febe;
          SUB_W'(4): dout_nxt = dl_bit;
          default:   dout_nxt = 1'b1;
        endcase
      end
    end
  end

endmodule

// File: rtl/ds3cb_ovh_gen.sv
`timescale 1ns/1ps
module ds3cb_ovh_gen #(
  parameter int SUBFRAMES  = 7,
  parameter int BLOCKS     = 8,
  parameter int BLOCK_BITS = 85,
  parameter int NUM_ALARMS = 4,
  parameter int RST_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_en,
  input  logic                  din,
  input  logic                  frame_gen_en,
  input  logic                  pbit_gen_en,
  input  logic [1:0]            rdi_mode,
  input  logic [NUM_ALARMS-1:0] alarm_en,
  input  logic [NUM_ALARMS-1:0] alarm_stat,
  input  logic                  febe_auto,
  input  logic                  febe_reg,
  input  logic                  cpar_err,
  input  logic                  feac_bit,
  input  logic                  dl_bit,
  output logic                  dout,
  output logic                  dout_vld,
  output logic                  mf_strobe
);
  import ds3cb_pkg::*;

  localparam int SUB_W = $clog2(SUBFRAMES);
  localparam int BLK_W = $clog2(BLOCKS);
  localparam int BIT_W = $clog2(BLOCK_BITS);

  // reset: asserted asynchronously, released after RST_STAGES edges
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_i_n = rst_pipe[RST_STAGES-1];

  logic [SUB_W-1:0] sub_idx;
  logic [BLK_W-1:0] blk_idx;
  logic [BIT_W-1:0] bit_idx;
  logic             at_start, at_last, is_payload;
  logic             par_prev, err_prev;

  ds3cb_pos_ctr #(
    .SUBFRAMES(SUBFRAMES), .BLOCKS(BLOCKS), .BLOCK_BITS(BLOCK_BITS),
    .SUB_W(SUB_W), .BLK_W(BLK_W), .BIT_W(BIT_W)
  ) u_pos (
    .clk(clk), .rst_n(rst_i_n), .adv(bit_en),
    .sub_idx(sub_idx), .blk_idx(blk_idx), .bit_idx(bit_idx),
    .at_start(at_start), .at_last(at_last)
  );

  assign is_payload = (bit_idx != '0);

  ds3cb_parity u_par (
    .clk(clk), .rst_n(rst_i_n), .adv(bit_en), .at_last(at_last),
    .is_payload(is_payload), .din(din), .cpar_err(cpar_err),
    .par_prev(par_prev), .err_prev(err_prev)
  );

  // per-alarm masking
  logic [NUM_ALARMS-1:0] alm_hit;
  for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_alarm
    assign alm_hit[g] = alarm_en[g] & alarm_stat[g];
  end

  frame_snap_t live_s, snap_q, snap_use;

  always_comb begin
    case (rdi_mode_e'(rdi_mode))
      RDI_AUTO:   live_s.rdi = ~|alm_hit;
      RDI_FORCE0: live_s.rdi = 1'b0;
      default:    live_s.rdi = 1'b1;
    endcase
    live_s.feac = feac_bit;
    live_s.febe = febe_auto ? ~err_prev : febe_reg;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)                snap_q <= '0;
    else if (bit_en && at_start) snap_q <= live_s;
  end

  // the opening bit uses the live values it is about to capture
  assign snap_use = at_start ? live_s : snap_q;

  logic dout_nxt;

  ds3cb_ovh_sel #(.SUB_W(SUB_W), .BLK_W(BLK_W), .BIT_W(BIT_W)) u_sel (
    .sub_idx(sub_idx), .blk_idx(blk_idx), .bit_idx(bit_idx), .din(din),
    .frame_gen_en(frame_gen_en), .pbit_gen_en(pbit_gen_en),
    .snap(snap_use), .dl_bit(dl_bit), .par_prev(par_prev),
    .dout_nxt(dout_nxt)
  );

  logic dout_q, vld_q, strb_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    dout_q <= 1'b0;
    else if (bit_en) dout_q <= dout_nxt;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      vld_q  <= 1'b0;
      strb_q <= 1'b0;
    end else begin
      vld_q  <= bit_en;
      strb_q <= bit_en & at_start;
    end
  end

  assign dout      = dout_q;
  assign dout_vld  = vld_q;
  assign mf_strobe = strb_q;

  assert_strobe_with_valid_R1: assert property (@(posedge clk) disable iff (!rst_i_n)
    mf_strobe |-> dout_vld);

  assert_payload_pass_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    bit_en && is_payload |=> dout == $past(din));

  assert_x2_matches_snapshot_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    bit_en && frame_gen_en && bit_idx == '0 && blk_idx == '0 && sub_idx == SUB_W'(1)
    |=> dout == snap_q.rdi);

  assert_snapshot_held_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(bit_en && at_start) |=> $stable(snap_q));

  assert_idle_output_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
    !bit_en |=> !dout_vld && $stable(dout));

endmodule

// File: tb/test_ds3cb_ovh_gen.sv
`timescale 1ns/1ps
module test_ds3cb_ovh_gen;

  localparam int BLK_BITS = 85;
  localparam int SF_BITS  = 680;
  localparam int MF_BITS  = 4760;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_en, din, frame_gen_en, pbit_gen_en;
  logic [1:0] rdi_mode;
  logic [3:0] alarm_en, alarm_stat;
  logic       febe_auto, febe_reg, cpar_err, feac_bit, dl_bit;
  logic       dout, dout_vld, mf_strobe;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;
  logic par_prev_m = 1'b0;
  logic err_prev_m = 1'b0;
  logic [14:0] lfsr = 15'h1ace;

  always #5 clk = ~clk;

  ds3cb_ovh_gen i_ds3cb_ovh_gen (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .din(din),
    .frame_gen_en(frame_gen_en), .pbit_gen_en(pbit_gen_en),
    .rdi_mode(rdi_mode), .alarm_en(alarm_en), .alarm_stat(alarm_stat),
    .febe_auto(febe_auto), .febe_reg(febe_reg), .cpar_err(cpar_err),
    .feac_bit(feac_bit), .dl_bit(dl_bit),
    .dout(dout), .dout_vld(dout_vld), .mf_strobe(mf_strobe)
  );

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input logic en);
    @(negedge clk);
    din    = b;
    bit_en = en;
    @(posedge clk);
    #2;
  endtask

  task automatic idle_check();
    logic prev;
    prev = dout;
    send_bit(1'b0, 1'b0);
    chk(dout_vld, 1'b0, "R11", "valid on idle");
    chk(dout, prev, "R11", "dout held on idle");
  endtask

  // one whole multiframe, every output bit compared
  task automatic run_mf(input int pat, input int chg_at, input int err_at, input int gap_every);
    logic  s_rdi, s_feac, s_febe, acc, b, e;
    int    sub, blk, bn;
    bit    late;
    string tag;
    acc = 1'b0;
    s_rdi = 1'b0; s_feac = 1'b0; s_febe = 1'b0;
    for (int i = 0; i < MF_BITS; i++) begin
      sub  = i / SF_BITS;
      blk  = (i % SF_BITS) / BLK_BITS;
      bn   = i % BLK_BITS;
      late = (chg_at >= 0) && (i > chg_at);
      if (i == chg_at) begin
        alarm_stat = ~alarm_stat;
        feac_bit   = ~feac_bit;
        febe_reg   = ~febe_reg;
      end
      dl_bit   = i[2] ^ i[5];
      cpar_err = (i == err_at);
      if (pat == 0)      b = 1'b0;
      else if (pat == 1) b = 1'b1;
      else begin
        lfsr = {lfsr[13:0], lfsr[14] ^ lfsr[13]};
        b = lfsr[0];
      end
      if (i == 0) begin
        if (rdi_mode == 2'b00)      s_rdi = ~|(alarm_en & alarm_stat);
        else if (rdi_mode == 2'b01) s_rdi = 1'b0;
        else                        s_rdi = 1'b1;
        s_feac = feac_bit;
        s_febe = febe_auto ? ~err_prev_m : febe_reg;
      end
      e = b;
      tag = frame_gen_en ? "R2" : "R9";
      if (bn == 0) begin
        if (blk == 0) begin
          if (sub < 2) begin
            if (frame_gen_en) begin
              e = s_rdi;
              tag = late ? "R10" : (rdi_mode == 2'b00) ? "R5" : "R4";
            end
          end else if (sub < 4) begin
            if (frame_gen_en || pbit_gen_en) e = par_prev_m;
            tag = frame_gen_en ? "R6" : "R9";
          end else begin
            if (frame_gen_en) begin e = (sub == 5); tag = "R3"; end
          end
        end else if (blk % 2 == 1) begin
          if (frame_gen_en) begin e = (blk == 1) || (blk == 7); tag = "R3"; end
        end else if (frame_gen_en) begin
          case (sub)
            0: begin
              e = (blk == 6) ? s_feac : 1'b1;
              tag = (late && blk == 6) ? "R10" : "R7";
            end
            2: begin e = par_prev_m; tag = "R6"; end
            3: begin e = s_febe; tag = late ? "R10" : "R8"; end
            4: begin e = dl_bit; tag = "R7"; end
            default: begin e = 1'b1; tag = "R7"; end
          endcase
        end
      end
      if (bn != 0) acc = acc ^ b;
      send_bit(b, 1'b1);
      chk(dout, e, tag, $sformatf("dout at bit %0d", i));
      chk(mf_strobe, (i == 0), "R1", $sformatf("strobe at bit %0d", i));
      chk(dout_vld, 1'b1, "R11", "valid after accepted bit");
      if (gap_every > 0 && (i % gap_every) == gap_every - 1) idle_check();
    end
    cpar_err   = 1'b0;
    par_prev_m = acc;
    err_prev_m = (err_at >= 0);
  endtask

  task automatic t_reset();
    chk(dout, 1'b0, "R11", "dout in reset");
    chk(dout_vld, 1'b0, "R11", "valid in reset");
    chk(mf_strobe, 1'b0, "R11", "strobe in reset");
  endtask

  task automatic t_framing();
    frame_gen_en = 1'b1; pbit_gen_en = 1'b0; rdi_mode = 2'b10;
    feac_bit = 1'b1; febe_auto = 1'b0; febe_reg = 1'b1;
    run_mf(0, -1, -1, 0);   // first frame: parity 0 (R6)
    run_mf(2, -1, -1, 0);   // R2, R3, R7
    run_mf(1, -1, -1, 0);   // parity of the random frame
  endtask

  task automatic t_rdi();
    feac_bit = 1'b0; febe_reg = 1'b0;
    rdi_mode = 2'b00; alarm_en = 4'b1111; alarm_stat = 4'b0000;
    run_mf(2, -1, -1, 0);   // R5: no alarm -> 1
    alarm_stat = 4'b0100;
    run_mf(2, -1, -1, 0);   // R5: enabled LOF -> 0
    alarm_en = 4'b1011;
    run_mf(2, -1, -1, 0);   // R5: LOF masked -> 1
    rdi_mode = 2'b01; alarm_stat = 4'b0000;
    run_mf(2, -1, -1, 0);   // R4: forced 0
  endtask

  task automatic t_snapshot();
    rdi_mode = 2'b00; alarm_en = 4'b1111; alarm_stat = 4'b0000;
    feac_bit = 1'b1; febe_auto = 1'b0; febe_reg = 1'b1;
    run_mf(2, 100, -1, 0);  // R10: changes after X1 ignored this frame
    run_mf(2, -1, -1, 0);   // new values now in force
  endtask

  task automatic t_febe();
    alarm_stat = 4'b0000; febe_auto = 1'b1;
    run_mf(2, -1, 3000, 0); // R8: error seen in this frame
    run_mf(2, -1, -1, 0);   // R8: FEBE 0
    run_mf(2, -1, -1, 0);   // R8: FEBE 1 again
  endtask

  task automatic t_bypass();
    frame_gen_en = 1'b0; pbit_gen_en = 1'b1;
    run_mf(2, -1, -1, 0);   // R9 with P bits
    run_mf(2, -1, -1, 0);
    pbit_gen_en = 1'b0;
    run_mf(2, -1, -1, 0);   // R9 full pass-through
  endtask

  task automatic t_gaps();
    frame_gen_en = 1'b1; pbit_gen_en = 1'b0; febe_auto = 1'b0;
    run_mf(2, -1, -1, 97);  // R1, R11 with idle cycles
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; din = 1'b0;
    frame_gen_en = 1'b1; pbit_gen_en = 1'b0; rdi_mode = 2'b10;
    alarm_en = 4'b0000; alarm_stat = 4'b0000;
    febe_auto = 1'b0; febe_reg = 1'b0; cpar_err = 1'b0;
    feac_bit = 1'b0; dl_bit = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_framing();
    t_rdi();
    t_snapshot();
    t_febe();
    t_bypass();
    t_gaps();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule